// File: doc/BRIEF.md
# Power-up strap latch sequencer

This block runs the start-up of a clock generator on a slow reference clock. After a synchronous power-on reset it waits for the analog supply to be valid and then counts a fixed settle delay. Next it waits for the active-low power-good input, brought in through a two-flop synchronizer, to read low. In that same cycle it captures the two frequency-select strap pins. From then on the pins are driven as reference-clock outputs, and any further movement on power-good or on the straps has no effect. After a parameterised enable wait, the block raises the outputs-enable.

The captured code is decoded into an output mode and a CPU rate selection. A register bit picks a high-range rate table. A second register bit, once seen after the straps are captured, locks the block into a test state. Only another power-on reset leaves that state. While in it, strap B is frozen, strap A turns back into an input, and strap A chooses, with no clock involved, between tri-stating every output and passing the reference clock through.

Top module: `strap_latch_seq`

## Requirements
- R1: While porRst is high and on the first cycle after it, strapLatched is 00, pinDir is 00 and outEnable is 0.
- R2: The settle delay lasts exactly DELAY_CYCLES cycles after supplyOk is first seen high. A power-good that is already low is acted on only after that delay, so pinDir[1] rises on the (DELAY_CYCLES+2)th rising edge after supplyOk goes high.
- R3: The straps are captured exactly once, as strapLatched = {strapB, strapA}. After capture, changes on strapA, strapB or pwrGoodN leave strapLatched unchanged until porRst.
- R4: pinDir = 00 (both pins inputs) before capture and 11 (both outputs) after capture in normal operation.
- R5: outEnable rises exactly ENABLE_CYCLES cycles after capture and stays high until porRst.
- R6: With the code {A,B} and hiTableReg = 0, the decode is: 00 gives modeOut normal (0) at rateSel 100 MHz (0); 10 gives 200 MHz (2); 11 gives 133 MHz (1); 01 gives modeOut reference pass-through (1) with rateSel none (7).
- R7: With hiTableReg = 1, codes 00, 01 and 10 give modeOut normal at rateSel 200 MHz (2), 400 MHz (4) and 266 MHz (3). Code 11 decodes as it does in the normal table.
- R8: If testModeReg is high in a cycle after capture, the block enters test mode on the next edge. pinDir becomes 10 and rateSel becomes 7. modeOut follows the live strapA pin with no clock edge: 1 gives tri-state (2) and 0 gives pass-through (1). strapB and strapLatched are ignored.
- R9: Test mode is left only by porRst. Clearing testModeReg has no effect.
- R10: pwrGoodN passes through two flops. When it falls while the block is waiting, capture happens on the third rising edge after the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| porRst | input | 1 | Synchronous power-on reset, active high |
| supplyOk | input | 1 | Analog supply valid |
| pwrGoodN | input | 1 | Active-low power-good, asynchronous |
| strapA | input | 1 | Frequency-select strap A |
| strapB | input | 1 | Frequency-select strap B |
| testModeReg | input | 1 | Register bit requesting test mode |
| hiTableReg | input | 1 | Register bit selecting the high-range table |
| strapLatched | output | 2 | Captured straps, B in bit 1, A in bit 0 |
| pinDir | output | 2 | Pin direction, 1 = output; bit 1 strap B pin, bit 0 strap A pin |
| outEnable | output | 1 | Clock outputs enabled |
| modeOut | output | 2 | 0 normal, 1 reference pass-through, 2 tri-state |
| rateSel | output | 3 | 0=100, 1=133, 2=200, 3=266, 4=400 MHz, 7=none |

## Verification
The hardest state to reach is test mode, because it can only be entered after a full sequence has run and a capture has taken place. It can only be left through another power-on reset. The bench walks each sweep point through supply-valid, the delay, the power-good fall and the enable wait, counting edges, and only then raises the test request. It then toggles strapA and strapB, with and without clock edges, to show that strap A acts asynchronously and strap B is frozen. A separate run holds power-good high past the delay so that the synchronizer latency can be measured on its own.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_REFPASS  = 2'd1,
    MODE_TRISTATE = 2'd2
  } outMode_t;

  localparam logic [2:0] RATE_100  = 3'd0;
  localparam logic [2:0] RATE_133  = 3'd1;
  localparam logic [2:0] RATE_200  = 3'd2;
  localparam logic [2:0] RATE_266  = 3'd3;
  localparam logic [2:0] RATE_400  = 3'd4;
  localparam logic [2:0] RATE_NONE = 3'd7;

  typedef enum logic [2:0] {
    ST_OFF, ST_DELAY, ST_WAITPG, ST_ENWAIT, ST_RUN
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic sampleNow;
    logic armTest;
  } seqStrobe_t;
endpackage

// File: rtl/strap_seq_ctrl.sv
module strap_seq_ctrl
  import strap_seq_pkg::*;
#(
  parameter int DELAY_CYCLES  = 8,
  parameter int ENABLE_CYCLES = 6
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       supplyOk,
  input  logic       pwrGoodN,
  input  logic       testModeReg,
  output seqStrobe_t strobe,
  output logic       outEnable
);
  localparam int MAXC = (DELAY_CYCLES > ENABLE_CYCLES) ? DELAY_CYCLES : ENABLE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLAST = CW'(DELAY_CYCLES - 1);
  localparam logic [CW-1:0] ELAST = CW'(ENABLE_CYCLES - 1);

  seqState_t state, stateNext;
  logic [CW-1:0] cnt, cntNext;
  logic pgMeta, pgSync;

  always_ff @(posedge clk) begin
    if (porRst) begin
      pgMeta <= 1'b1;
      pgSync <= 1'b1;
    end else begin
      pgMeta <= pwrGoodN;
      pgSync <= pgMeta;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt + 1'b1;
    unique case (state)
      ST_OFF: begin
        cntNext = '0;
        if (supplyOk) stateNext = ST_DELAY;
      end
      ST_DELAY: if (cnt == DLAST) begin
        stateNext = ST_WAITPG;
        cntNext   = '0;
      end
      ST_WAITPG: begin
        cntNext = '0;
        if (!pgSync) stateNext = ST_ENWAIT;
      end
      ST_ENWAIT: if (cnt == ELAST) begin
        stateNext = ST_RUN;
        cntNext   = '0;
      end
      ST_RUN: cntNext = '0;
      default: begin
        stateNext = ST_OFF;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (porRst) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign strobe.sampleNow = (state == ST_WAITPG) && !pgSync;
  assign strobe.armTest   = ((state == ST_ENWAIT) || (state == ST_RUN)) && testModeReg;
  assign outEnable        = (state == ST_RUN);
endmodule

// File: rtl/strap_seq_path.sv
module strap_seq_path
  import strap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       porRst,
  input  seqStrobe_t strobe,
  input  logic       strapA,
  input  logic       strapB,
  input  logic       hiTableReg,
  output logic [1:0] strapLatched,
  output logic [1:0] pinDir,
  output logic [1:0] modeOut,
  output logic [2:0] rateSel
);
  logic [1:0] latchQ;
  logic sampledQ, testQ;
  outMode_t modeN;
  logic [2:0] rateN;

  always_ff @(posedge clk) begin
    if (porRst) begin
      latchQ   <= 2'b00;
      sampledQ <= 1'b0;
      testQ    <= 1'b0;
    end else begin
      if (strobe.sampleNow && !sampledQ) begin
        latchQ   <= {strapB, strapA};
        sampledQ <= 1'b1;
      end
      if (strobe.armTest) testQ <= 1'b1;
    end
  end

  // code written as {A,B}
  always_comb begin
    logic [1:0] code;
    code  = {latchQ[0], latchQ[1]};
    modeN = MODE_NORMAL;
    rateN = RATE_NONE;
    if (testQ) begin
      modeN = strapA ? MODE_TRISTATE : MODE_REFPASS;
    end else if (hiTableReg && code != 2'b11) begin
      unique case (code)
        2'b00:   rateN = RATE_200;
        2'b01:   rateN = RATE_400;
        default: rateN = RATE_266;
      endcase
    end else begin
      unique case (code)
        2'b00:   rateN = RATE_100;
        2'b10:   rateN = RATE_200;
        2'b11:   rateN = RATE_133;
        default: modeN = MODE_REFPASS;
      endcase
    end
  end

  assign strapLatched = latchQ;
  assign pinDir       = {sampledQ, sampledQ & ~testQ};
  assign modeOut      = modeN;
  assign rateSel      = rateN;
endmodule

// File: rtl/strap_latch_seq.sv
module strap_latch_seq
  import strap_seq_pkg::*;
#(
  parameter int DELAY_CYCLES  = 8,
  parameter int ENABLE_CYCLES = 6
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       supplyOk,
  input  logic       pwrGoodN,
  input  logic       strapA,
  input  logic       strapB,
  input  logic       testModeReg,
  input  logic       hiTableReg,
  output logic [1:0] strapLatched,
  output logic [1:0] pinDir,
  output logic       outEnable,
  output logic [1:0] modeOut,
  output logic [2:0] rateSel
);
  seqStrobe_t strobe;

  strap_seq_ctrl #(.DELAY_CYCLES(DELAY_CYCLES), .ENABLE_CYCLES(ENABLE_CYCLES)) ctrl (
    .clk(clk), .porRst(porRst), .supplyOk(supplyOk), .pwrGoodN(pwrGoodN),
    .testModeReg(testModeReg), .strobe(strobe), .outEnable(outEnable)
  );

  strap_seq_path path (
    .clk(clk), .porRst(porRst), .strobe(strobe), .strapA(strapA), .strapB(strapB),
    .hiTableReg(hiTableReg), .strapLatched(strapLatched), .pinDir(pinDir),
    .modeOut(modeOut), .rateSel(rateSel)
  );
endmodule

// File: rtl/strap_latch_seq_chk.sv
module strap_latch_seq_chk (
  input logic       clk,
  input logic       porRst,
  input logic       strapA,
  input logic [1:0] strapLatched,
  input logic [1:0] pinDir,
  input logic       outEnable,
  input logic [1:0] modeOut
);
  assert_reset_state_R1: assert property (@(posedge clk)
    porRst |=> (strapLatched == 2'b00 && pinDir == 2'b00 && !outEnable));

  assert_latch_frozen_R3: assert property (@(posedge clk) disable iff (porRst)
    pinDir[1] |=> $stable(strapLatched));

  assert_pins_stay_out_R4: assert property (@(posedge clk) disable iff (porRst)
    pinDir[1] |=> pinDir[1]);

  assert_enable_after_capture_R5: assert property (@(posedge clk) disable iff (porRst)
    outEnable |-> pinDir[1]);

  assert_enable_sticky_R5: assert property (@(posedge clk) disable iff (porRst)
    outEnable |=> outEnable);

  assert_tristate_only_test_R8: assert property (@(posedge clk) disable iff (porRst)
    (modeOut == 2'd2) |-> (strapA && pinDir == 2'b10));

  assert_test_sticky_R9: assert property (@(posedge clk) disable iff (porRst)
    (pinDir == 2'b10) |=> (pinDir == 2'b10));
endmodule

bind strap_latch_seq strap_latch_seq_chk chk (
  .clk(clk), .porRst(porRst), .strapA(strapA), .strapLatched(strapLatched),
  .pinDir(pinDir), .outEnable(outEnable), .modeOut(modeOut)
);

// File: tb/strap_latch_seq_test.sv
module strap_latch_seq_test;
  localparam int D = 8;
  localparam int E = 6;

  logic clk = 1'b0;
  logic porRst = 1'b1, supplyOk = 1'b0, pwrGoodN = 1'b1;
  logic strapA = 1'b0, strapB = 1'b0, testModeReg = 1'b0, hiTableReg = 1'b0;
  logic [1:0] strapLatched, pinDir, modeOut;
  logic outEnable;
  logic [2:0] rateSel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strap_latch_seq #(.DELAY_CYCLES(D), .ENABLE_CYCLES(E)) uut (
    .clk(clk), .porRst(porRst), .supplyOk(supplyOk), .pwrGoodN(pwrGoodN),
    .strapA(strapA), .strapB(strapB), .testModeReg(testModeReg), .hiTableReg(hiTableReg),
    .strapLatched(strapLatched), .pinDir(pinDir), .outEnable(outEnable),
    .modeOut(modeOut), .rateSel(rateSel)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doPor();
    porRst = 1'b1; supplyOk = 1'b0; pwrGoodN = 1'b1; testModeReg = 1'b0;
    tick(2);
    porRst = 1'b0;
    tick(1);
  endtask

  function automatic int expMode(int a, int b, int hi);
    int code = a * 2 + b;
    if (code == 1 && !(hi == 1)) return 1;
    return 0;
  endfunction

  function automatic int expRate(int a, int b, int hi);
    int code = a * 2 + b;
    if (hi == 1 && code != 3) return (code == 0) ? 2 : (code == 1) ? 4 : 3;
    case (code)
      0: return 0;
      2: return 2;
      3: return 1;
      default: return 7;
    endcase
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(1);
    check("R1 latch in reset", strapLatched, 0);
    check("R1 pinDir in reset", pinDir, 0);
    check("R1 outEnable in reset", outEnable, 0);
    porRst = 1'b0;
    tick(1);
    check("R1 pinDir after reset", pinDir, 0);

    for (int hi = 0; hi < 2; hi++) begin
      for (int code = 0; code < 4; code++) begin
        int a = code / 2;
        int b = code % 2;
        doPor();
        strapA = a[0]; strapB = b[0]; hiTableReg = hi[0];
        pwrGoodN = 1'b0; supplyOk = 1'b1;
        tick(1 + D);
        check("R2 no capture during delay", pinDir, 0);
        tick(1);
        check("R4 pins turned to outputs", pinDir, 3);
        check("R3 captured value", strapLatched, b * 2 + a);
        tick(E - 1);
        check("R5 enable not yet", outEnable, 0);
        tick(1);
        check("R5 enable on time", outEnable, 1);
        check(hi ? "R7 mode" : "R6 mode", modeOut, expMode(a, b, hi));
        check(hi ? "R7 rate" : "R6 rate", rateSel, expRate(a, b, hi));
        strapA = ~strapA; strapB = ~strapB; pwrGoodN = 1'b1;
        tick(3);
        pwrGoodN = 1'b0;
        tick(3);
        check("R3 latch ignores later edges", strapLatched, b * 2 + a);
        check("R5 enable stays", outEnable, 1);
      end
    end

    // synchronizer latency
    doPor();
    hiTableReg = 1'b0; strapA = 1'b1; strapB = 1'b1;
    pwrGoodN = 1'b1; supplyOk = 1'b1;
    tick(D + 4);
    check("R10 waiting with pg high", pinDir, 0);
    pwrGoodN = 1'b0;
    tick(2);
    check("R10 not captured after two edges", pinDir, 0);
    tick(1);
    check("R10 captured on third edge", pinDir, 3);

    // test mode
    doPor();
    strapA = 1'b0; strapB = 1'b0; pwrGoodN = 1'b0; supplyOk = 1'b1;
    tick(D + E + 4);
    check("R6 normal before test", modeOut, 0);
    testModeReg = 1'b1;
    tick(1);
    check("R8 pinDir in test", pinDir, 2);
    check("R8 rate none in test", rateSel, 7);
    strapA = 1'b1; #1;
    check("R8 A high tri-states", modeOut, 2);
    strapA = 1'b0; #1;
    check("R8 A low passes reference", modeOut, 1);
    strapB = 1'b1; tick(2);
    check("R8 B ignored", modeOut, 1);
    check("R8 latch unchanged", strapLatched, 0);
    testModeReg = 1'b0;
    tick(3);
    check("R9 still in test", pinDir, 2);
    strapA = 1'b1; #1;
    check("R9 A still selects", modeOut, 2);
    doPor();
    check("R9 reset leaves test", modeOut, 0);
    check("R9 reset clears pins", pinDir, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule